// File: doc/BRIEF.md
# Two-Wire Slave Front End for an 8-bit DAC Register

This block is the digital front end of a small voltage-output converter. It listens on a two-wire serial bus as a write-only slave. The block has no clock on the bus side, so it samples SCL and SDA with a faster system clock. Each line passes through a two-flop synchroniser and then a stable-count filter, which removes spikes shorter than `FILT_LEN` system clocks. START, repeated START and STOP are detected on the filtered lines.

A transaction carries two bytes:

- **Address byte.** The first seven bits are a fixed pattern plus two strap pins. The eighth bit does not select read or write; it is a power-down request.
- **Code byte.** The second byte is the converter code.

The block commits the new code and the new power mode together, and only on a STOP that follows a complete second byte. When power-down is requested, the master clocks the second byte out of the block. The block leaves SDA released during those bits, so the master reads all ones.

The outputs are:

- the registered code;
- a power-down flag;
- an effective code, which is held at zero while powered down.

States of the controller:

- `ST_IDLE`: waiting for START.
- `ST_ADDR`: shifting the address byte.
- `ST_ADDR_ACK`: the 9th pulse of the address byte; the pull-down is on when the address matched.
- `ST_DATA`: shifting the code byte.
- `ST_DATA_ACK`: the 9th pulse of the code byte.
- `ST_WAIT_STOP`: a full code byte is held and the block waits for STOP.
- `ST_IGNORE`: the address did not match; the block waits for the next START or STOP.

Transitions between states:

- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- In `ST_ADDR`, the falling SCL after 8 bits goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- In `ST_ADDR_ACK`, falling SCL goes to `ST_DATA`.
- In `ST_DATA`, the falling SCL after 8 bits goes to `ST_DATA_ACK`.
- In `ST_DATA_ACK`, falling SCL goes to `ST_WAIT_STOP`.

Top module: `twdac_slave`

## Requirements
- R1: After reset the code output is 0, the power-down flag is 0, the effective code is 0 and SDA is released.
- R2: The address byte matches when its bits 7..1 equal {0,1,1,0,0,strap_i[1],strap_i[0]}. This gives the 8-bit addresses 0x60, 0x62, 0x64 and 0x66. On a match, the block pulls SDA low during the 9th SCL pulse.
- R3: A non-matching address, the general call 0x00 included, gets no acknowledge on either byte and changes nothing. The block stays idle until the next START.
- R4: When bit 0 of the address is 0, the second byte is received MSB first and acknowledged. At STOP, the code output takes that byte and the power-down flag clears.
- R5: When bit 0 of the address is 1, the block does not pull SDA during the second byte, so the master reads 0xFF, and it gives no acknowledge. At STOP, the power-down flag sets and the code output keeps its previous value.
- R6: A STOP that directly follows the acknowledged address byte changes neither the code nor the power-down flag.
- R7: A repeated START discards a received but uncommitted byte. The new transaction that follows behaves normally.
- R8: The effective code equals the code output while the power-down flag is 0, and is 0 while it is 1.
- R9: A spike of fewer than `FILT_LEN` system clocks on SCL or SDA neither adds a bit nor creates a START or STOP.
- R10: SDA is pulled low only during an acknowledge pulse. During the bits of a write byte the bus carries exactly what the master sent.
- R11: A STOP after only part of the second byte changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| strap_i | input | 2 | Address straps; bit 1 gives address bit 2, bit 0 gives address bit 1 |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| code_o | output | 8 | Committed converter code |
| pdown_o | output | 1 | Committed power-down flag |
| out_code_o | output | 8 | Effective code, zero while powered down |

## Verification
The bench builds the block with `FILT_LEN` = 4 and a bus quarter-phase of 16 system clocks. Filter and synchroniser latency therefore stay well inside each bus phase. Spikes of two clocks are shorter than the filter window, so the bench can inject them on SCL during a low phase and on SDA during a high phase, which brings R9 within reach. Random strap settings, addresses, power bits, codes and transaction endings cover all four addresses and every way a transaction can end: full STOP, STOP after the address, partial byte and repeated START.

// File: rtl/twdac_pkg.sv
package twdac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_WAIT_STOP,
        ST_IGNORE
    } twdac_state_e;

    // fixed upper five bits of the 7-bit slave address
    localparam logic [4:0] ADDR_FIXED = 5'b01100;
endpackage

// File: rtl/twdac_filt.sv
module twdac_filt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] != filt_o) begin
                if (cnt_q == CNT_LAST) begin
                    filt_o <= sync_q[1];
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R9
    filt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/twdac_fsm.sv
module twdac_fsm
    import twdac_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [1:0]        strap_i,
    output logic              ack_o,
    output logic [CODE_W-1:0] code_o,
    output logic              pdown_o
);
    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(CODE_W);

    twdac_state_e     st_q, st_d;
    logic             scl_d, sda_d;
    logic             scl_rise, scl_fall, start_ev, stop_ev;
    logic [CNT_W-1:0] bit_q;
    logic [7:0]       sh_q;
    logic             pd_q;
    logic             addr_hit;
    logic             byte_done;

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign start_ev  = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_ev   = scl_f & scl_d & ~sda_d & sda_f;
    assign addr_hit  = (sh_q[7:1] == {ADDR_FIXED, strap_i});
    assign byte_done = scl_fall && (bit_q == BYTE_END);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      st_d = ST_IDLE;
            ST_ADDR:      if (byte_done) st_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK:  if (scl_fall) st_d = ST_DATA;
            ST_DATA:      if (byte_done) st_d = ST_DATA_ACK;
            ST_DATA_ACK:  if (scl_fall) st_d = ST_WAIT_STOP;
            ST_WAIT_STOP: st_d = ST_WAIT_STOP;
            ST_IGNORE:    st_d = ST_IGNORE;
            default:      st_d = ST_IDLE;
        endcase
        if (start_ev)     st_d = ST_ADDR;
        else if (stop_ev) st_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            bit_q   <= '0;
            sh_q    <= '0;
            pd_q    <= 1'b0;
            ack_o   <= 1'b0;
            code_o  <= '0;
            pdown_o <= 1'b0;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            if (start_ev || stop_ev) begin
                bit_q <= '0;
                ack_o <= 1'b0;
                if (stop_ev && st_q == ST_WAIT_STOP) begin
                    pdown_o <= pd_q;
                    if (!pd_q) code_o <= sh_q;
                end
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            bit_q <= bit_q + 1'b1;
                        end
                        if (byte_done) begin
                            if (st_q == ST_ADDR) begin
                                pd_q  <= sh_q[0];
                                ack_o <= addr_hit;
                            end else begin
                                ack_o <= ~pd_q;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) begin
                            ack_o <= 1'b0;
                            bit_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q == ST_ADDR));
    // R10
    ack_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (st_q == ST_ADDR_ACK || st_q == ST_DATA_ACK));
    // R10
    ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> !scl_f);
    // R4
    code_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> $past(stop_ev));
    // R6
    pdown_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pdown_o) |-> $past(stop_ev));
endmodule

// File: rtl/twdac_slave.sv
module twdac_slave #(
    parameter int FILT_LEN = 4,
    parameter int CODE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_pull_o,
    output logic [CODE_W-1:0] code_o,
    output logic              pdown_o,
    output logic [CODE_W-1:0] out_code_o
);
    logic scl_f, sda_f;

    twdac_filt #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .filt_o(scl_f));
    twdac_filt #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .filt_o(sda_f));

    twdac_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .strap_i(strap_i), .ack_o(sda_pull_o), .code_o(code_o),
        .pdown_o(pdown_o));

    assign out_code_o = pdown_o ? '0 : code_o;
endmodule

// File: tb/twdac_slave_bench.sv
module twdac_slave_bench;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_pull;
    logic [7:0] code, out_code;
    logic       pdown;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_code = 8'h00;
    logic       exp_pd = 1'b0;

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull;

    twdac_slave u_twdac_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .strap_i(strap), .sda_pull_o(sda_pull), .code_o(code),
        .pdown_o(pdown), .out_code_o(out_code));

    function automatic logic [6:0] my_addr(input logic [1:0] s);
        return {5'b01100, s};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b, input logic glitch, output logic r);
        m_sda = b; wq(Q);
        m_scl = 1'b1; wq(5);
        r = sda_bus;
        if (glitch) begin
            m_sda = ~b; wq(2); m_sda = b; wq(Q - 7);
        end else wq(Q - 5);
        m_scl = 1'b0;
        if (glitch) begin
            wq(5); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(Q - 7);
        end else wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int gi,
                             output logic ack, output logic [7:0] rb);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], (i == gi), r);
            rb[i] = r;
        end
        send_bit(1'b1, 1'b0, r);
        ack = ~r;
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R4 code"}, code, exp_code);
        chk({tag, " R5 pdown"}, pdown, exp_pd);
        chk({tag, " R8 out_code"}, out_code, exp_pd ? 0 : exp_code);
    endtask

    // mode: 0 full+stop, 1 stop after address, 2 partial byte, 3 repeated start
    task automatic txn(input logic [6:0] a7, input logic pd, input logic [7:0] d,
                       input int mode, input int gi, input logic [7:0] d2);
        logic ack, hit, r;
        logic [7:0] rb;
        hit = (a7 == my_addr(strap));
        bus_start();
        send_byte({a7, pd}, -1, ack, rb);
        if (hit) chk("R2 address ack", ack, 1);
        else     chk("R3 no ack on foreign address", ack, 0);
        if (mode == 1) begin
            bus_stop();
            check_outputs("R6 stop after address");
        end else if (mode == 2) begin
            for (int i = 7; i >= 4; i--) send_bit(d[i], 1'b0, r);
            bus_stop();
            check_outputs("R11 partial byte");
        end else begin
            send_byte(pd ? 8'hFF : d, gi, ack, rb);
            if (!hit) chk("R3 no ack on data", ack, 0);
            else if (pd) begin
                chk("R5 data reads ones", rb, 8'hFF);
                chk("R5 no data ack", ack, 0);
            end else begin
                chk("R4 data ack", ack, 1);
                chk("R10 bus carries master bits", rb, d);
            end
            if (mode == 3) begin
                bus_start();
                send_byte({my_addr(strap), 1'b0}, -1, ack, rb);
                chk("R7 address ack after repeated start", ack, 1);
                send_byte(d2, -1, ack, rb);
                chk("R7 data ack after repeated start", ack, 1);
                bus_stop();
                exp_code = d2; exp_pd = 1'b0;
                check_outputs("R7 repeated start");
            end else begin
                bus_stop();
                if (hit) begin
                    exp_pd = pd;
                    if (!pd) exp_code = d;
                end
                check_outputs(gi >= 0 ? "R9 glitch" : "R4/R5 commit");
            end
        end
        wq(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [6:0] a7;
        seed = $urandom(20240611);
        wq(4);
        // R1: reset state
        chk("R1 code", code, 0);
        chk("R1 pdown", pdown, 0);
        chk("R1 out_code", out_code, 0);
        chk("R1 sda released", sda_pull, 0);
        rst_n = 1'b1;
        wq(Q);
        chk("R1 sda released after reset", sda_pull, 0);

        strap = 2'b10;
        txn(my_addr(strap), 1'b0, 8'hA5, 0, -1, 8'h00);
        txn(my_addr(strap), 1'b0, 8'h3C, 0, 3, 8'h00);     // R9
        txn(my_addr(strap), 1'b1, 8'h00, 0, -1, 8'h00);    // R5
        txn(my_addr(strap), 1'b0, 8'h77, 1, -1, 8'h00);    // R6
        txn(7'h00, 1'b0, 8'h11, 0, -1, 8'h00);             // R3 general call
        txn(my_addr(strap), 1'b0, 8'h5A, 3, -1, 8'hC3);    // R7
        txn(my_addr(strap), 1'b0, 8'hF0, 2, -1, 8'h00);    // R11
        txn(my_addr(strap), 1'b0, 8'hFF, 0, -1, 8'h00);

        for (int n = 0; n < 40; n++) begin
            strap = 2'($urandom % 4);
            a7 = my_addr(strap);
            if ($urandom % 4 == 0) begin
                a7 = 7'($urandom % 128);
                if (a7 == my_addr(strap)) a7 = 7'h00;
            end
            txn(a7, 1'($urandom % 2), 8'($urandom), int'($urandom % 4),
                ($urandom % 5 == 0) ? int'($urandom % 8) : -1, 8'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule